// File: doc/BRIEF.md
# Tone and Noise Channel Mixer

This block makes the raw per-channel amplitudes of a three-voice sound generator. A free-running prescaler divides the master clock enable by 16. Three tone dividers run from that tick and each drives a square wave. A shared divider steps a 17-bit linear feedback shift register, and the register's low bit is the noise source.

Each channel ANDs two terms. Each term is either its source bit or an active-high disable from the mixer control word. The channel then passes either its fixed 4-bit volume or the shared envelope level to its output, and drives zero when the gate is closed. The register file, the envelope generator and the analog conversion sit outside the block and feed it through plain inputs.

Top module: `tone_noise_mix`

## Requirements
- R1: After reset the square waves are low and the shift register holds 1, so its low bit (the noise bit) is 1. A tone-only channel outputs 0 and a noise-only channel outputs its level until the first divider event.
- R2: Each tone square wave changes state once every 16×P enabled clocks, with P the full 12-bit period. The first rise after reset comes 16×P enabled clocks after reset is released.
- R3: A tone or noise period of 0 times exactly like a period of 1.
- R4: While clk_en_i is low, no prescaler, divider, square wave or shift register state moves. Timing resumes where it stopped.
- R5: Mixer bits 0..2 disable tone on channels A, B, C and bits 3..5 disable noise on A, B, C. A 1 disables a source. A channel with both sources disabled outputs its selected level steadily.
- R6: The shift register shifts once every 16×N enabled clocks, with N the noise period. The new bit 16 is bit 0 XOR bit 3, and the noise bit is bit 0.
- R7: When volume bit 4 is 1, the channel level is env_lvl_i and volume bits 3:0 have no effect.
- R8: When volume bit 4 is 0, the channel level is volume bits 3:0, including 0.
- R9: The output is the level when (tone bit OR tone disable) AND (noise bit OR noise disable) is true, and 0 otherwise.
- R10: A tone divider wraps on the first tick where its count plus one reaches or passes the period. A period lowered below the current count therefore toggles on the very next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_i | input | 1 | Master-rate clock enable |
| tone_per_a_i | input | 12 | Channel A tone period |
| tone_per_b_i | input | 12 | Channel B tone period |
| tone_per_c_i | input | 12 | Channel C tone period |
| noise_per_i | input | 5 | Noise period |
| mix_ctrl_i | input | 6 | Tone disables [2:0], noise disables [5:3] |
| vol_a_i | input | 5 | Channel A volume, bit 4 selects envelope |
| vol_b_i | input | 5 | Channel B volume, bit 4 selects envelope |
| vol_c_i | input | 5 | Channel C volume, bit 4 selects envelope |
| env_lvl_i | input | 4 | Shared envelope level |
| amp_a_o | output | 4 | Channel A amplitude |
| amp_b_o | output | 4 | Channel B amplitude |
| amp_c_o | output | 4 | Channel C amplitude |

## Verification
The bench measures the first rise and the following half periods of a square wave, using a short period, a period with coarse bits set, and period 0. A divider that compared with strict greater-than, or that ignored the upper period bits, would be off by one tick or by thousands of clocks. It stalls the enable both before the first tick and in mid-wave, and checks that the remaining time is neither reset nor skipped. It also tracks the noise bit against an independent shift-register model, and against the AND with a running tone, where a wrong tap or a wrong gate polarity would diverge within a few steps. Finally it lowers a period below the running count to catch a divider that waits for an exact match and wraps through 4096.

// File: rtl/tnm_pkg.sv
package tnm_pkg;
  localparam int unsigned CH_N = 3;

  typedef struct packed {
    logic noise_off;
    logic tone_off;
  } chan_cfg_t;
endpackage

// File: rtl/tnm_prescale.sv
module tnm_prescale #(
  parameter int unsigned W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (en_i) cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && (cnt_q == '1);

  assert_tick_spacing_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q));
endmodule

// File: rtl/tnm_divider.sv
module tnm_divider #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [W-1:0] period_i,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] eff;
  logic [W:0]   nxt;

  // zero period treated as one
  assign eff    = (period_i == '0) ? {{(W-1){1'b0}}, 1'b1} : period_i;
  assign nxt    = {1'b0, cnt_q} + 1'b1;
  assign wrap_o = tick_i && (nxt >= {1'b0, eff});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= wrap_o ? '0 : nxt[W-1:0];
  end

  assert_cnt_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
  assert_wrap_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_q == '0));
endmodule

// File: rtl/tnm_tone_gen.sv
module tnm_tone_gen #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [W-1:0] period_i,
  output logic         sq_o
);
  logic wrap;

  tnm_divider #(.W(W)) i_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .period_i (period_i),
    .wrap_o   (wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sq_o <= 1'b0;
    else if (wrap) sq_o <= ~sq_o;
  end

  assert_toggle_on_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sq_o != $past(sq_o)) |-> $past(tick_i));
endmodule

// File: rtl/tnm_noise_gen.sv
module tnm_noise_gen #(
  parameter int unsigned PW  = 5,
  parameter int unsigned LW  = 17,
  parameter int unsigned TAP = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [PW-1:0] period_i,
  output logic          noise_o
);
  logic          step;
  logic [LW-1:0] lfsr_q;

  tnm_divider #(.W(PW)) i_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .period_i (period_i),
    .wrap_o   (step)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   lfsr_q <= {{(LW-1){1'b0}}, 1'b1};
    else if (step) lfsr_q <= {lfsr_q[0] ^ lfsr_q[TAP], lfsr_q[LW-1:1]};
  end

  assign noise_o = lfsr_q[0];

  assert_lfsr_live_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_q != '0);
  assert_lfsr_shift_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lfsr_q != $past(lfsr_q)) |-> (lfsr_q[LW-2:0] == $past(lfsr_q[LW-1:1])));
endmodule

// File: rtl/tnm_chan_mix.sv
module tnm_chan_mix
  import tnm_pkg::*;
#(
  parameter int unsigned LVL_W = 4
) (
  input  logic             tone_i,
  input  logic             noise_i,
  input  chan_cfg_t        cfg_i,
  input  logic [LVL_W:0]   vol_i,
  input  logic [LVL_W-1:0] env_i,
  output logic [LVL_W-1:0] amp_o
);
  logic [LVL_W-1:0] lvl;
  logic             gate;

  assign lvl   = vol_i[LVL_W] ? env_i : vol_i[LVL_W-1:0];
  assign gate  = (tone_i | cfg_i.tone_off) & (noise_i | cfg_i.noise_off);
  assign amp_o = gate ? lvl : '0;
endmodule

// File: rtl/tone_noise_mix.sv
module tone_noise_mix
  import tnm_pkg::*;
#(
  parameter int unsigned TONE_W   = 12,
  parameter int unsigned NOISE_W  = 5,
  parameter int unsigned LFSR_W   = 17,
  parameter int unsigned LFSR_TAP = 3,
  parameter int unsigned PRESC_W  = 4,
  parameter int unsigned LVL_W    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_en_i,
  input  logic [TONE_W-1:0] tone_per_a_i,
  input  logic [TONE_W-1:0] tone_per_b_i,
  input  logic [TONE_W-1:0] tone_per_c_i,
  input  logic [NOISE_W-1:0] noise_per_i,
  input  logic [2*CH_N-1:0] mix_ctrl_i,
  input  logic [LVL_W:0]    vol_a_i,
  input  logic [LVL_W:0]    vol_b_i,
  input  logic [LVL_W:0]    vol_c_i,
  input  logic [LVL_W-1:0]  env_lvl_i,
  output logic [LVL_W-1:0]  amp_a_o,
  output logic [LVL_W-1:0]  amp_b_o,
  output logic [LVL_W-1:0]  amp_c_o
);
  logic              tick;
  logic              noise;
  logic [CH_N-1:0]   tone;
  logic [TONE_W-1:0] per_w [CH_N];
  logic [LVL_W:0]    vol_w [CH_N];
  logic [LVL_W-1:0]  amp_w [CH_N];
  chan_cfg_t         cfg_w [CH_N];

  assign per_w[0] = tone_per_a_i;
  assign per_w[1] = tone_per_b_i;
  assign per_w[2] = tone_per_c_i;
  assign vol_w[0] = vol_a_i;
  assign vol_w[1] = vol_b_i;
  assign vol_w[2] = vol_c_i;
  assign amp_a_o  = amp_w[0];
  assign amp_b_o  = amp_w[1];
  assign amp_c_o  = amp_w[2];

  tnm_prescale #(.W(PRESC_W)) i_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (clk_en_i),
    .tick_o (tick)
  );

  tnm_noise_gen #(.PW(NOISE_W), .LW(LFSR_W), .TAP(LFSR_TAP)) i_noise (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .period_i (noise_per_i),
    .noise_o  (noise)
  );

  for (genvar g = 0; g < CH_N; g++) begin : g_ch
    assign cfg_w[g] = '{noise_off: mix_ctrl_i[CH_N+g], tone_off: mix_ctrl_i[g]};

    tnm_tone_gen #(.W(TONE_W)) i_tone (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick),
      .period_i (per_w[g]),
      .sq_o     (tone[g])
    );

    tnm_chan_mix #(.LVL_W(LVL_W)) i_mix (
      .tone_i  (tone[g]),
      .noise_i (noise),
      .cfg_i   (cfg_w[g]),
      .vol_i   (vol_w[g]),
      .env_i   (env_lvl_i),
      .amp_o   (amp_w[g])
    );

    assert_steady_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mix_ctrl_i[g] && mix_ctrl_i[CH_N+g]) |->
        (amp_w[g] == (vol_w[g][LVL_W] ? env_lvl_i : vol_w[g][LVL_W-1:0])));
    assert_env_sel_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vol_w[g][LVL_W] |-> (amp_w[g] == '0 || amp_w[g] == env_lvl_i));
    assert_fixed_sel_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !vol_w[g][LVL_W] |-> (amp_w[g] == '0 || amp_w[g] == vol_w[g][LVL_W-1:0]));
    assert_tone_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!mix_ctrl_i[g] && !tone[g]) |-> (amp_w[g] == '0));
    assert_noise_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!mix_ctrl_i[CH_N+g] && !noise) |-> (amp_w[g] == '0));
  end
endmodule

// File: tb/test_tone_noise_mix.sv
module test_tone_noise_mix;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clk_en = 1'b1;
  logic [11:0] tone_a = 12'd1, tone_b = 12'd1, tone_c = 12'd1;
  logic [4:0]  noise_per = 5'd1;
  logic [5:0]  mix = 6'h3F;
  logic [4:0]  vol_a = 5'd15, vol_b = 5'd15, vol_c = 5'd15;
  logic [3:0]  env = 4'd0;
  logic [3:0]  amp_a, amp_b, amp_c;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  tone_noise_mix i_tone_noise_mix (
    .clk_i(clk), .rst_ni(rst_ni), .clk_en_i(clk_en),
    .tone_per_a_i(tone_a), .tone_per_b_i(tone_b), .tone_per_c_i(tone_c),
    .noise_per_i(noise_per), .mix_ctrl_i(mix),
    .vol_a_i(vol_a), .vol_b_i(vol_b), .vol_c_i(vol_c), .env_lvl_i(env),
    .amp_a_o(amp_a), .amp_b_o(amp_b), .amp_c_o(amp_c)
  );

  function automatic int amp_of(input int ch);
    return (ch == 0) ? int'(amp_a) : (ch == 1) ? int'(amp_b) : int'(amp_c);
  endfunction

  function automatic logic [16:0] lfsr_step(input logic [16:0] s);
    return {s[0] ^ s[3], s[16:1]};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    clk_en = 1'b1;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic count_until(input int ch, input bit want_on, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (((amp_of(ch) != 0) != want_on) && n < 20000);
  endtask

  task automatic t_reset();
    mix = 6'b111_000; vol_a = 5'd15; vol_b = 5'd15; vol_c = 5'd15;
    tone_a = 12'd1; tone_b = 12'd1; tone_c = 12'd1;
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk);
    chk("R1 in-reset amp_a", amp_a, 0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 amp_a", amp_a, 0);
    chk("R1 amp_b", amp_b, 0);
    chk("R1 amp_c", amp_c, 0);
    mix = 6'b000_111;
    do_reset();
    repeat (2) @(negedge clk);
    chk("R1 noise seed amp_a", amp_a, 15);
  endtask

  task automatic t_tone(input int ch, input logic [11:0] per, input string tag);
    int n;
    int eff;
    eff = (per == 0) ? 1 : int'(per);
    mix = 6'b111_111 & ~(6'b1 << ch);
    vol_a = 5'd7; vol_b = 5'd7; vol_c = 5'd7;
    tone_a = 12'd1; tone_b = 12'd1; tone_c = 12'd1;
    if (ch == 0) tone_a = per; else if (ch == 1) tone_b = per; else tone_c = per;
    do_reset();
    count_until(ch, 1'b1, n); chk({tag, " first rise"}, n, 16 * eff);
    chk({tag, " high level"}, amp_of(ch), 7);
    count_until(ch, 1'b0, n); chk({tag, " high span"}, n, 16 * eff);
    count_until(ch, 1'b1, n); chk({tag, " low span"}, n, 16 * eff);
  endtask

  task automatic t_freeze();
    int n;
    mix = 6'b111_110; tone_a = 12'd2; vol_a = 5'd15;
    do_reset();
    clk_en = 1'b0;
    repeat (300) @(negedge clk);
    chk("R4 frozen before tick", amp_a, 0);
    clk_en = 1'b1;
    count_until(0, 1'b1, n); chk("R4 rise after resume", n, 32);
    repeat (10) @(negedge clk);
    clk_en = 1'b0;
    repeat (50) @(negedge clk);
    chk("R4 frozen mid wave", amp_a, 15);
    clk_en = 1'b1;
    count_until(0, 1'b0, n); chk("R4 remaining span", n, 22);
  endtask

  task automatic t_levels();
    mix = 6'h3F; vol_a = 5'd5; vol_b = 5'd10; vol_c = 5'd15; env = 4'd2;
    do_reset();
    @(negedge clk);
    chk("R5 steady a", amp_a, 5);
    chk("R5 steady b", amp_b, 10);
    repeat (100) @(negedge clk);
    chk("R5 steady c late", amp_c, 15);
    vol_a = 5'h13; env = 4'd9;
    @(negedge clk);
    chk("R7 env level", amp_a, 9);
    env = 4'd4;
    @(negedge clk);
    chk("R7 env follows", amp_a, 4);
    vol_a = 5'h1F;
    @(negedge clk);
    chk("R7 low bits ignored", amp_a, 4);
    vol_b = 5'h06;
    @(negedge clk);
    chk("R8 fixed level", amp_b, 6);
    vol_c = 5'h00;
    @(negedge clk);
    chk("R8 zero volume", amp_c, 0);
  endtask

  task automatic t_noise();
    logic [16:0] m;
    mix = 6'b110_111; noise_per = 5'd2; vol_a = 5'd11;
    do_reset();
    m = 17'h1;
    repeat (8) @(negedge clk);
    chk("R6 noise step 0", amp_a, m[0] ? 11 : 0);
    for (int k = 1; k < 48; k++) begin
      repeat (32) @(negedge clk);
      m = lfsr_step(m);
      chk("R6 noise step", amp_a, m[0] ? 11 : 0);
    end
  endtask

  task automatic t_gate();
    logic [16:0] m;
    bit          t;
    mix = 6'b110_110; tone_a = 12'd1; noise_per = 5'd0; vol_a = 5'd12;
    do_reset();
    m = 17'h1; t = 1'b0;
    repeat (8) @(negedge clk);
    chk("R9 gate step 0", amp_a, (t && m[0]) ? 12 : 0);
    for (int k = 1; k < 64; k++) begin
      repeat (16) @(negedge clk);
      m = lfsr_step(m);
      t = ~t;
      chk("R9 R3 gate step", amp_a, (t && m[0]) ? 12 : 0);
    end
  endtask

  task automatic t_shrink();
    mix = 6'b111_110; tone_a = 12'd100; vol_a = 5'd9;
    do_reset();
    repeat (640) @(negedge clk);
    chk("R10 before shrink", amp_a, 0);
    tone_a = 12'd5;
    repeat (15) @(negedge clk);
    chk("R10 no early toggle", amp_a, 0);
    @(negedge clk);
    chk("R10 toggle next tick", amp_a, 9);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_tone(0, 12'd3, "R2 ch A");
    t_tone(1, 12'h105, "R2 ch B coarse");
    t_tone(2, 12'd0, "R3 ch C zero");
    t_freeze();
    t_levels();
    t_noise();
    t_gate();
    t_shrink();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule